// File: doc/BRIEF.md
# Width-Switchable Accumulator and ALU Slice

This block is the accumulator register and its arithmetic/logic unit for a small processor datapath. A run-time width control decides whether each operation works on the full 16-bit accumulator or only on its low byte. In the narrow setting the upper byte is not lost. It is held as a hidden byte that narrow operations never touch, and a dedicated exchange operation swaps it with the low byte.

Each cycle where the write enable is high, the block applies one operation to the accumulator and a 16-bit operand. The operations are load, add with carry, subtract with borrow, AND, OR, XOR and byte exchange. The result and the updated carry, negative, overflow and zero flags appear on the registered outputs after the next rising clock edge. The carry flag is kept inside the block and feeds the next add or subtract. Instruction decode, memory access, decimal arithmetic and the other processor registers belong to the surrounding core.

Top module: `acc_alu_slice`

## Requirements
- R1: After reset the accumulator reads 0x0000 and the flags are carry=0, negative=0, overflow=0 and zero=1.
- R2: The operation code is 3 bits: 0=load, 1=add with carry, 2=subtract with borrow, 3=AND, 4=OR, 5=XOR, 6=byte exchange, 7=no operation. When the write enable is low, or the code is 7, the accumulator and all four flags are left unchanged.
- R3: When emu_mode=0 and acc_narrow=0, every operation works on all 16 bits of the accumulator and the operand.
- R4: When acc_narrow=1, every operation except exchange works on the low byte only. The upper accumulator byte keeps its value.
- R5: When emu_mode=1, the accumulator behaves as 8 bits wide whatever the value of acc_narrow.
- R6: Add with carry computes acc + operand + carry. The new carry is the carry out of bit 15 (wide) or bit 7 (narrow).
- R7: Subtract with borrow computes acc + ~operand + carry. Carry=1 afterwards means no borrow occurred.
- R8: After an add or a subtract, overflow is set exactly when both addends (acc and the operand or its complement) have the same sign at the active width and the result's sign differs.
- R9: Negative is the top bit of the active-width result, bit 15 or bit 7. Zero is set when the active-width result is all zeros. In narrow mode the preserved upper byte is excluded from the zero test.
- R10: AND, OR and XOR update only negative and zero. Carry and overflow are left unchanged.
- R11: Exchange swaps the two bytes of the full 16-bit accumulator in every mode. Negative and zero then reflect the new low byte as an 8-bit value, and carry and overflow are left unchanged.
- R12: Load copies the operand into the accumulator at the active width. It updates only negative and zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_valid | input | 1 | Write enable: apply op_code this cycle |
| op_code | input | 3 | Operation select (encoding in R2) |
| operand | input | 16 | Second operand or load value |
| emu_mode | input | 1 | Emulation flag, forces 8-bit width when 1 |
| acc_narrow | input | 1 | Accumulator width select, 1 = 8-bit |
| acc_q | output | 16 | Accumulator value |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |

## Verification
Some properties hold on every cycle, and the checker tests them continuously. The hidden upper byte survives every narrow non-exchange operation. Idle cycles and the no-operation code change nothing. Logic operations leave carry and overflow untouched. An exchange produces exactly the swapped word. Negative and zero always agree with the active-width accumulator value. The arithmetic values themselves need the bench's directed scenarios, with hand-computed expected values: carry out at the two widths, borrow semantics, signed overflow at each width, and the emulation flag overriding the width bit.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_ADC  = 3'd1,
    OP_SBC  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_XCHG = 3'd6,
    OP_NONE = 3'd7
  } acc_op_e;

  typedef struct packed {
    logic c;
    logic n;
    logic v;
    logic z;
  } acc_flags_t;

  localparam acc_flags_t FLAGS_RESET = '{c: 1'b0, n: 1'b0, v: 1'b0, z: 1'b1};

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/acc_width_sel.sv
module acc_width_sel (
  input  logic emu_mode,
  input  logic acc_narrow,
  output logic narrow
);

  // Emulation forces byte width; otherwise the select bit decides.
  always_comb begin
    narrow = emu_mode | acc_narrow;
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  acc_op_e            op,
  input  logic [DATA_W-1:0]  acc_cur,
  input  logic [DATA_W-1:0]  opnd,
  input  acc_flags_t         flags_cur,
  input  logic               narrow,
  output logic [DATA_W-1:0]  raw_res,
  output acc_flags_t         flags_nxt
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int W_MSB  = DATA_W - 1;
  localparam int N_MSB  = BYTE_W - 1;

  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   sum_wide;
  logic [BYTE_W:0]   sum_nar;
  logic              ovf_wide;
  logic              ovf_nar;
  logic              arith_c;
  logic              arith_v;
  logic [DATA_W-1:0] arith_res;

  // Subtraction adds the one's complement of the operand.
  always_comb begin
    addend = (op == OP_SBC) ? ~opnd : opnd;
  end

  always_comb begin
    sum_wide = {1'b0, acc_cur} + {1'b0, addend} + {{DATA_W{1'b0}}, flags_cur.c};
    sum_nar  = {1'b0, acc_cur[N_MSB:0]} + {1'b0, addend[N_MSB:0]}
             + {{BYTE_W{1'b0}}, flags_cur.c};
  end

  always_comb begin
    ovf_wide = (acc_cur[W_MSB] == addend[W_MSB]) && (sum_wide[W_MSB] != acc_cur[W_MSB]);
    ovf_nar  = (acc_cur[N_MSB] == addend[N_MSB]) && (sum_nar[N_MSB] != acc_cur[N_MSB]);
  end

  always_comb begin
    if (narrow) begin
      arith_res = {acc_cur[W_MSB:BYTE_W], sum_nar[N_MSB:0]};
      arith_c   = sum_nar[BYTE_W];
      arith_v   = ovf_nar;
    end else begin
      arith_res = sum_wide[W_MSB:0];
      arith_c   = sum_wide[DATA_W];
      arith_v   = ovf_wide;
    end
  end

  // Raw result; byte preservation is applied by the merge stage.
  always_comb begin
    unique case (op)
      OP_LOAD: raw_res = opnd;
      OP_ADC,
      OP_SBC:  raw_res = arith_res;
      OP_AND:  raw_res = acc_cur & opnd;
      OP_OR:   raw_res = acc_cur | opnd;
      OP_XOR:  raw_res = acc_cur ^ opnd;
      OP_XCHG: raw_res = {acc_cur[N_MSB:0], acc_cur[W_MSB:BYTE_W]};
      default: raw_res = acc_cur;
    endcase
  end

  always_comb begin
    flags_nxt = flags_cur;
    unique case (op)
      OP_ADC, OP_SBC: begin
        flags_nxt.c = arith_c;
        flags_nxt.v = arith_v;
        flags_nxt.n = narrow ? raw_res[N_MSB] : raw_res[W_MSB];
        flags_nxt.z = narrow ? (raw_res[N_MSB:0] == '0) : (raw_res == '0);
      end
      OP_LOAD, OP_AND, OP_OR, OP_XOR: begin
        flags_nxt.n = narrow ? raw_res[N_MSB] : raw_res[W_MSB];
        flags_nxt.z = narrow ? (raw_res[N_MSB:0] == '0) : (raw_res == '0);
      end
      OP_XCHG: begin
        flags_nxt.n = raw_res[N_MSB];
        flags_nxt.z = (raw_res[N_MSB:0] == '0);
      end
      default: begin
        flags_nxt = flags_cur;
      end
    endcase
  end

endmodule

// File: rtl/acc_byte_merge.sv
module acc_byte_merge
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  acc_op_e            op,
  input  logic               narrow,
  input  logic [DATA_W-1:0]  acc_cur,
  input  logic [DATA_W-1:0]  raw_res,
  output logic [DATA_W-1:0]  acc_nxt
);

  localparam int BYTE_W = DATA_W / 2;

  logic keep_high;

  always_comb begin
    keep_high = narrow && (op != OP_XCHG);
  end

  // Each byte lane is chosen on its own; the low lane always takes the result.
  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    if (lane == 0) begin : g_low
      always_comb acc_nxt[BYTE_W-1:0] = raw_res[BYTE_W-1:0];
    end else begin : g_high
      always_comb acc_nxt[DATA_W-1:BYTE_W] =
        keep_high ? acc_cur[DATA_W-1:BYTE_W] : raw_res[DATA_W-1:BYTE_W];
    end
  end

endmodule

// File: rtl/acc_alu_slice.sv
module acc_alu_slice
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] operand,
  input  logic              emu_mode,
  input  logic              acc_narrow,
  output logic [DATA_W-1:0] acc_q,
  output logic              flag_c,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_z
);

  logic              rst_n_int;
  logic              narrow;
  acc_op_e           op;
  logic [DATA_W-1:0] acc_r;
  logic [DATA_W-1:0] acc_nxt;
  logic [DATA_W-1:0] raw_res;
  acc_flags_t        flags_r;
  acc_flags_t        flags_nxt;
  logic              upd_en;

  acc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  acc_width_sel u_width (
    .emu_mode   (emu_mode),
    .acc_narrow (acc_narrow),
    .narrow     (narrow)
  );

  always_comb begin
    op     = acc_op_e'(op_code);
    upd_en = op_valid && (op != OP_NONE);
  end

  acc_alu_core #(.DATA_W(DATA_W)) u_core (
    .op        (op),
    .acc_cur   (acc_r),
    .opnd      (operand),
    .flags_cur (flags_r),
    .narrow    (narrow),
    .raw_res   (raw_res),
    .flags_nxt (flags_nxt)
  );

  acc_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .op      (op),
    .narrow  (narrow),
    .acc_cur (acc_r),
    .raw_res (raw_res),
    .acc_nxt (acc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      acc_r   <= '0;
      flags_r <= FLAGS_RESET;
    end else if (upd_en) begin
      acc_r   <= acc_nxt;
      flags_r <= flags_nxt;
    end
  end

  assign acc_q  = acc_r;
  assign flag_c = flags_r.c;
  assign flag_n = flags_r.n;
  assign flag_v = flags_r.v;
  assign flag_z = flags_r.z;

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              emu_mode,
  input logic              acc_narrow,
  input logic [DATA_W-1:0] acc_q,
  input logic              flag_c,
  input logic              flag_n,
  input logic              flag_v,
  input logic              flag_z
);

  localparam int BYTE_W = DATA_W / 2;

  logic is_narrow;
  logic is_logic_op;
  logic is_xchg;
  logic is_idle;
  logic is_width_op;

  always_comb begin
    is_narrow   = emu_mode || acc_narrow;
    is_logic_op = (op_code == 3'd3) || (op_code == 3'd4) || (op_code == 3'd5);
    is_xchg     = (op_code == 3'd6);
    is_idle     = !op_valid || (op_code == 3'd7);
    is_width_op = (op_code <= 3'd5);
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |=> ($stable(acc_q) && $stable({flag_c, flag_n, flag_v, flag_z})));

  assert_high_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_narrow && is_width_op) |=>
      (acc_q[DATA_W-1:BYTE_W] == $past(acc_q[DATA_W-1:BYTE_W])));

  assert_logic_cv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_logic_op) |=> ($stable(flag_c) && $stable(flag_v)));

  assert_xchg_swap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_xchg) |=>
      ((acc_q == {$past(acc_q[BYTE_W-1:0]), $past(acc_q[DATA_W-1:BYTE_W])})
       && $stable(flag_c) && $stable(flag_v)
       && (flag_n == acc_q[BYTE_W-1]) && (flag_z == (acc_q[BYTE_W-1:0] == '0))));

  assert_wide_nz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !is_narrow && is_width_op) |=>
      ((flag_n == acc_q[DATA_W-1]) && (flag_z == (acc_q == '0))));

  assert_narrow_nz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_narrow && (op_code != 3'd7)) |=>
      ((flag_n == acc_q[BYTE_W-1]) && (flag_z == (acc_q[BYTE_W-1:0] == '0))));

endmodule

bind acc_alu_slice acc_alu_checker #(.DATA_W(DATA_W)) u_acc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .emu_mode   (emu_mode),
  .acc_narrow (acc_narrow),
  .acc_q      (acc_q),
  .flag_c     (flag_c),
  .flag_n     (flag_n),
  .flag_v     (flag_v),
  .flag_z     (flag_z)
);

// File: tb/tb_acc_alu_slice.sv
module tb_acc_alu_slice;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [15:0] operand;
  logic        emu_mode;
  logic        acc_narrow;
  logic [15:0] acc_q;
  logic        flag_c, flag_n, flag_v, flag_z;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [2:0] C_LOAD = 3'd0, C_ADC = 3'd1, C_SBC = 3'd2, C_AND = 3'd3,
                         C_OR = 3'd4, C_XOR = 3'd5, C_XCHG = 3'd6, C_NONE = 3'd7;

  acc_alu_slice dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .emu_mode(emu_mode), .acc_narrow(acc_narrow),
    .acc_q(acc_q), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] e_acc,
                       input logic ec, input logic en, input logic ev, input logic ez);
    checks++;
    if (acc_q !== e_acc || flag_c !== ec || flag_n !== en || flag_v !== ev || flag_z !== ez) begin
      errors++;
      $display("FAIL %s: acc=%h c%b n%b v%b z%b expected acc=%h c%b n%b v%b z%b",
               req, acc_q, flag_c, flag_n, flag_v, flag_z, e_acc, ec, en, ev, ez);
    end
  endtask

  // Drive one operation on a falling edge; the result is visible one falling edge later.
  task automatic apply(input logic [2:0] code, input logic [15:0] val, input logic valid);
    @(negedge clk);
    op_code  = code;
    operand  = val;
    op_valid = valid;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic set_mode(input logic emu, input logic nar);
    @(negedge clk);
    emu_mode   = emu;
    acc_narrow = nar;
  endtask

  task automatic t_reset();
    check("R1 reset", 16'h0000, 0, 0, 0, 1);
  endtask

  task automatic t_wide_add();
    set_mode(0, 0);
    apply(C_LOAD, 16'h8001, 1); check("R12 R3 wide load", 16'h8001, 0, 1, 0, 0);
    apply(C_ADC, 16'h7FFF, 1);  check("R6 R3 wide carry out", 16'h0000, 1, 0, 0, 1);
    apply(C_ADC, 16'h0000, 1);  check("R6 carry in", 16'h0001, 0, 0, 0, 0);
    apply(C_LOAD, 16'h7FFF, 1); check("R12 load keeps cv", 16'h7FFF, 0, 0, 0, 0);
    apply(C_ADC, 16'h0001, 1);  check("R8 wide overflow", 16'h8000, 0, 1, 1, 0);
  endtask

  task automatic t_wide_sub();
    apply(C_SBC, 16'h0001, 1);  check("R7 R8 wide sbc borrow in", 16'h7FFE, 1, 0, 1, 0);
    apply(C_SBC, 16'h7FFE, 1);  check("R7 R9 wide sbc to zero", 16'h0000, 1, 0, 0, 1);
  endtask

  task automatic t_narrow();
    set_mode(0, 0);
    apply(C_LOAD, 16'hAB12, 1); check("R12 wide load", 16'hAB12, 1, 1, 0, 0);
    set_mode(0, 1);
    apply(C_LOAD, 16'h34FF, 1); check("R4 narrow load", 16'hABFF, 1, 1, 0, 0);
    apply(C_ADC, 16'h0001, 1);  check("R4 R6 narrow carry out", 16'hAB01, 1, 0, 0, 0);
    apply(C_ADC, 16'h007F, 1);  check("R8 narrow overflow", 16'hAB81, 0, 1, 1, 0);
    apply(C_SBC, 16'h0081, 1);  check("R7 narrow borrow", 16'hABFF, 0, 1, 0, 0);
    apply(C_AND, 16'h0000, 1);  check("R9 narrow zero ignores high", 16'hAB00, 0, 0, 0, 1);
  endtask

  task automatic t_logic();
    set_mode(0, 0);
    apply(C_LOAD, 16'h0000, 1);
    apply(C_ADC, 16'h0000, 1);
    apply(C_LOAD, 16'h8000, 1);
    apply(C_ADC, 16'h8000, 1);  check("R6 R8 set c and v", 16'h0000, 1, 0, 1, 1);
    apply(C_OR, 16'h0F0F, 1);   check("R10 or", 16'h0F0F, 1, 0, 1, 0);
    apply(C_XOR, 16'hFFFF, 1);  check("R10 xor", 16'hF0F0, 1, 1, 1, 0);
    apply(C_AND, 16'h0F0F, 1);  check("R10 and", 16'h0000, 1, 0, 1, 1);
  endtask

  task automatic t_emu();
    set_mode(0, 0);
    apply(C_LOAD, 16'h5500, 1); check("R3 wide load", 16'h5500, 1, 0, 1, 0);
    set_mode(1, 0);
    apply(C_LOAD, 16'h00AA, 1); check("R5 emu narrow load", 16'h55AA, 1, 1, 1, 0);
    apply(C_AND, 16'h000F, 1);  check("R5 emu and", 16'h550A, 1, 0, 1, 0);
    apply(C_XOR, 16'h000A, 1);  check("R5 R9 emu zero", 16'h5500, 1, 0, 1, 1);
  endtask

  task automatic t_xchg();
    logic c0, v0;
    set_mode(0, 0);
    apply(C_LOAD, 16'h00C3, 1);
    c0 = flag_c; v0 = flag_v;
    apply(C_XCHG, 16'hFFFF, 1); check("R11 wide xchg", 16'hC300, c0, 0, v0, 1);
    set_mode(0, 1);
    apply(C_XCHG, 16'h0000, 1); check("R11 narrow xchg", 16'h00C3, c0, 1, v0, 0);
  endtask

  task automatic t_hold();
    logic [15:0] a0;
    logic c0, n0, v0, z0;
    set_mode(0, 0);
    a0 = acc_q; c0 = flag_c; n0 = flag_n; v0 = flag_v; z0 = flag_z;
    apply(C_ADC, 16'h1234, 0);  check("R2 write enable low", a0, c0, n0, v0, z0);
    apply(C_NONE, 16'h1234, 1); check("R2 code 7", a0, c0, n0, v0, z0);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = C_NONE; operand = '0;
    emu_mode = 1'b0; acc_narrow = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_wide_add();
    t_wide_sub();
    t_narrow();
    t_logic();
    t_emu();
    t_xchg();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule